// File: doc/BRIEF.md
# Three-to-Two Serial Track Decoder

This block turns a serial stream of raw track bits into parallel data words. The track code places two data bits in every group of three raw bits. Each accepted raw bit enters a short history register at its low end. When the third bit of a group arrives, the decoder reads the newest four history bits, derives a two-bit data pair from them, and shifts that pair into a word accumulator. One of the code patterns takes its upper data bit from the group before, so the history keeps more bits than the group itself.

A pattern outside the legal set raises a one-cycle decode error. The pair for that group is zero, and decoding carries on without a break. When the accumulator has taken enough pairs to fill a word, the word is presented with a one-cycle strobe and the accumulator starts again from empty. A synchronous clear realigns the group phase and empties the history, the accumulator and the output word, so the decoder can be framed to the start of a data field by the logic that drives it.

Top module: `fm_pair_decoder`

## Requirements
- R1: After reset or clear, `word_o` is all zeros and `word_vld_o` and `dec_err_o` are low.
- R2: Only cycles with `bit_vld_i` high move the decoder. A group is decoded on every third accepted bit, and no strobe appears on any other cycle.
- R3: When the newest four history bits (bit 0 = the latest raw bit) are 4'hA or 4'hE, the data pair is 2'b00.
- R4: When the newest four history bits are 4'hB, 4'hD or 4'hF, the data pair is history bits [2:1].
- R5: When the newest four history bits are 4'h5 or 4'h7, the data pair is {history bit 5, history bit 1}. History bit 5 belongs to the previous group.
- R6: Any other four-bit pattern pulses `dec_err_o` for one cycle, appends the pair 2'b00 and leaves decoding running.
- R7: Each pair shifts into the accumulator at its low end. After WORD_W/2 groups the word appears on `word_o`, with the first group in the top two bits and `word_vld_o` high for one cycle. The accumulator then restarts empty.
- R8: After clear the history holds the value 1. The first group is therefore classified as if the raw bits 0,0,1 came before it.
- R9: `clr_i` takes priority over a bit arriving in the same cycle. It resets the group phase, the pair count, the accumulator and the history, and produces no strobe.
- R10: A decode error on the last group of a word is reported in the same cycle as that word's strobe.
- R11: Outputs are registered. Each strobe appears in the cycle after the clock edge that accepts the third raw bit of its group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous realignment clear |
| bit_i | input | 1 | Raw track bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` |
| word_o | output | WORD_W | Last completed data word |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |
| dec_err_o | output | 1 | One-cycle strobe for an illegal pattern |

## Verification
Completing a word and reporting a decode error can happen in the same cycle when the final group of a word carries an illegal pattern. The bench provokes this by sending seventeen legal filler groups and then the raw group 000 after a group ending in 1, which gives the pattern 4'h8. It expects both strobes together and a zero low pair in the word. A clear arriving with the third bit of a group is a second collision; the bench drives one and expects no strobe and an empty restart. Every pairing of previous group and current group is swept, so all 64 six-bit windows reach the classifier.

// File: rtl/fmd_pkg.sv
package fmd_pkg;
   // raw bits per code group and data bits per group
   localparam int GROUP_RAW = 3;
   localparam int PAIR_W    = 2;
   // stored history; the classifier window is the history plus the live bit
   localparam int HIST_W    = 5;
   localparam int WIN_W     = HIST_W + 1;
   localparam logic [HIST_W-1:0] HIST_INIT = HIST_W'(1);

   // pattern sets over the newest four window bits, one bit per pattern
   localparam logic [15:0] PAT_ZERO   = 16'h4400; // patterns A, E
   localparam logic [15:0] PAT_MID    = 16'hA800; // patterns B, D, F
   localparam logic [15:0] PAT_BORROW = 16'h00A0; // patterns 5, 7
   localparam logic [15:0] PAT_LEGAL  = PAT_ZERO | PAT_MID | PAT_BORROW;
endpackage

// File: rtl/fmd_history.sv
module fmd_history
   import fmd_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             bit_i,
   input  logic             bit_vld_i,
   output logic             grp_o,
   output logic [WIN_W-1:0] win_o
);
   localparam int PH_W = $clog2(GROUP_RAW);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(GROUP_RAW - 1);

   logic [HIST_W-1:0] hist_q;
   logic [PH_W-1:0]   phase_q;

   assign win_o = {hist_q, bit_i};
   assign grp_o = bit_vld_i && !clr_i && (phase_q == PH_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hist_q  <= HIST_INIT;
         phase_q <= '0;
      end else if (clr_i) begin
         hist_q  <= HIST_INIT;
         phase_q <= '0;
      end else if (bit_vld_i) begin
         hist_q  <= win_o[HIST_W-1:0];
         phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
      end
   end

   a_r2_phase_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_q <= PH_LAST);

   a_r8_clear_history: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (hist_q == HIST_INIT) && (phase_q == '0));
endmodule

// File: rtl/fmd_classify.sv
module fmd_classify
   import fmd_pkg::*;
#(
   parameter bit USE_MASK = 1'b0
) (
   input  logic [WIN_W-1:0]  win_i,
   output logic [PAIR_W-1:0] pair_o,
   output logic              bad_o
);
   logic unused_win4;
   assign unused_win4 = win_i[4];

   generate
      if (USE_MASK) begin : g_mask
         always_comb begin
            bad_o  = !PAT_LEGAL[win_i[3:0]];
            pair_o = '0;
            if (PAT_MID[win_i[3:0]])
               pair_o = win_i[2:1];
            else if (PAT_BORROW[win_i[3:0]])
               pair_o = {win_i[5], win_i[1]};
         end
      end else begin : g_case
         always_comb begin
            bad_o  = 1'b0;
            pair_o = '0;
            case (win_i[3:0])
               4'hA, 4'hE:       pair_o = '0;
               4'hB, 4'hD, 4'hF: pair_o = win_i[2:1];
               4'h5, 4'h7:       pair_o = {win_i[5], win_i[1]};
               default:          bad_o  = 1'b1;
            endcase
         end
      end
   endgenerate

   always_comb begin
      if (bad_o) begin
         a_r6_bad_pair_zero: assert (pair_o == '0);
      end
   end
endmodule

// File: rtl/fmd_pack.sv
module fmd_pack
   import fmd_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              grp_i,
   input  logic [PAIR_W-1:0] pair_i,
   input  logic              bad_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o,
   output logic              err_o
);
   localparam int GROUPS = WORD_W / PAIR_W;
   localparam int CNT_W  = $clog2(GROUPS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GROUPS - 1);

   logic [WORD_W-1:0] acc_q;
   logic [WORD_W-1:0] acc_nxt;
   logic [CNT_W-1:0]  cnt_q;

   assign acc_nxt = {acc_q[WORD_W-PAIR_W-1:0], pair_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q      <= '0;
         cnt_q      <= '0;
         word_o     <= '0;
         word_vld_o <= 1'b0;
         err_o      <= 1'b0;
      end else if (clr_i) begin
         acc_q      <= '0;
         cnt_q      <= '0;
         word_o     <= '0;
         word_vld_o <= 1'b0;
         err_o      <= 1'b0;
      end else begin
         word_vld_o <= 1'b0;
         err_o      <= grp_i && bad_i;
         if (grp_i) begin
            if (cnt_q == CNT_LAST) begin
               word_o     <= acc_nxt;
               word_vld_o <= 1'b1;
               acc_q      <= '0;
               cnt_q      <= '0;
            end else begin
               acc_q <= acc_nxt;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_LAST);

   a_r7_word_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_vld_o |=> !word_vld_o);

   a_r6_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> !err_o);

   a_r7_word_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !grp_i) |=> $stable(word_o));

   a_r11_err_follows_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!grp_i) |=> !err_o && !word_vld_o);
endmodule

// File: rtl/fm_pair_decoder.sv
module fm_pair_decoder
   import fmd_pkg::*;
#(
   parameter int WORD_W   = 36,
   parameter bit USE_MASK = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              bit_i,
   input  logic              bit_vld_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o,
   output logic              dec_err_o
);
   generate
      if ((WORD_W % PAIR_W) != 0) begin : g_bad_width
         $error("WORD_W must be a multiple of the pair width");
      end
      if (WORD_W < 2 * PAIR_W) begin : g_bad_small
         $error("WORD_W must hold at least two pairs");
      end
   endgenerate

   logic              grp;
   logic [WIN_W-1:0]  win;
   logic [PAIR_W-1:0] pair;
   logic              bad;

   fmd_history u_hist (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_i),
      .bit_i     (bit_i),
      .bit_vld_i (bit_vld_i),
      .grp_o     (grp),
      .win_o     (win)
   );

   fmd_classify #(.USE_MASK(USE_MASK)) u_class (
      .win_i  (win),
      .pair_o (pair),
      .bad_o  (bad)
   );

   fmd_pack #(.WORD_W(WORD_W)) u_pack (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr_i),
      .grp_i      (grp),
      .pair_i     (pair),
      .bad_i      (bad),
      .word_o     (word_o),
      .word_vld_o (word_vld_o),
      .err_o      (dec_err_o)
   );

   a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bit_vld_i |=> !word_vld_o && !dec_err_o);

   a_r9_clear_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !word_vld_o && !dec_err_o && (word_o == '0));
endmodule

// File: tb/fm_pair_decoder_bench.sv
module fm_pair_decoder_bench;
   localparam int W = 36;

   logic         clk_i = 1'b0;
   logic         rst_ni = 1'b0;
   logic         clr_i = 1'b0;
   logic         bit_i = 1'b0;
   logic         bit_vld_i = 1'b0;
   logic [W-1:0] word_o;
   logic         word_vld_o;
   logic         dec_err_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // bench model state, built from the requirements
   int           m_hist;
   int           m_ph;
   int           m_cnt;
   logic [W-1:0] m_acc;
   logic [W-1:0] last_word;
   bit           seen_err;
   bit           seen_wv;

   always #4 clk_i = ~clk_i;

   fm_pair_decoder #(.WORD_W(W)) u_fm_pair_decoder (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr_i),
      .bit_i      (bit_i),
      .bit_vld_i  (bit_vld_i),
      .word_o     (word_o),
      .word_vld_o (word_vld_o),
      .dec_err_o  (dec_err_o)
   );

   task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R3 R4 R5 R6 table over the six-bit window
   function automatic logic [2:0] ref_pair(input logic [5:0] w);
      // bit 2 = illegal, bits 1:0 = pair
      case (w[3:0])
         4'hA, 4'hE:       return 3'b000;
         4'hB, 4'hD, 4'hF: return {1'b0, w[2], w[1]};
         4'h5, 4'h7:       return {1'b0, w[5], w[1]};
         default:          return 3'b100;
      endcase
   endfunction

   function automatic string pat_tag(input logic [3:0] p);
      case (p)
         4'hA, 4'hE:       return "R3";
         4'hB, 4'hD, 4'hF: return "R4";
         4'h5, 4'h7:       return "R5";
         default:          return "R6";
      endcase
   endfunction

   task automatic model_clear();
      m_hist = 1;
      m_ph   = 0;
      m_cnt  = 0;
      m_acc  = '0;
   endtask

   task automatic send_bit(input logic b);
      logic [2:0] pr;
      bit e_err;
      bit e_wv;
      logic [W-1:0] e_word;
      @(negedge clk_i);
      clr_i = 1'b0;
      bit_vld_i = 1'b1;
      bit_i = b;
      e_err = 1'b0;
      e_wv = 1'b0;
      e_word = '0;
      m_hist = ((m_hist << 1) | int'(b)) & 63;
      m_ph++;
      if (m_ph == 3) begin
         m_ph = 0;
         pr = ref_pair(6'(m_hist));
         e_err = pr[2];
         m_acc = {m_acc[W-3:0], pr[1:0]};
         m_cnt++;
         if (m_cnt == W / 2) begin
            e_wv = 1'b1;
            e_word = m_acc;
            m_acc = '0;
            m_cnt = 0;
         end
      end
      @(posedge clk_i);
      #1;
      seen_err = dec_err_o;
      seen_wv  = word_vld_o;
      // R11 R2: strobes appear exactly after the third accepted bit
      check(dec_err_o == e_err, "R6 error strobe", W'(dec_err_o), W'(e_err));
      check(word_vld_o == e_wv, "R7 word strobe", W'(word_vld_o), W'(e_wv));
      if (e_wv) begin
         check(word_o == e_word, "R7 word value", word_o, e_word);
         last_word = word_o;
      end
   endtask

   task automatic send_group(input logic [2:0] g);
      send_bit(g[2]);
      send_bit(g[1]);
      send_bit(g[0]);
   endtask

   task automatic idle(input logic junk);
      @(negedge clk_i);
      clr_i = 1'b0;
      bit_vld_i = 1'b0;
      bit_i = junk;
      @(posedge clk_i);
      #1;
      check(!dec_err_o && !word_vld_o, "R2 idle bit ignored",
            W'({dec_err_o, word_vld_o}), '0);
   endtask

   task automatic do_clear(input bit with_bit);
      @(negedge clk_i);
      clr_i = 1'b1;
      bit_vld_i = with_bit;
      bit_i = 1'b1;
      @(posedge clk_i);
      #1;
      check(!dec_err_o && !word_vld_o, "R9 clear quiet",
            W'({dec_err_o, word_vld_o}), '0);
      check(word_o == '0, "R1 clear empties word", word_o, '0);
      model_clear();
      @(negedge clk_i);
      clr_i = 1'b0;
      bit_vld_i = 1'b0;
   endtask

   initial begin
      logic [2:0] pe;
      model_clear();
      last_word = '0;
      repeat (3) @(posedge clk_i);
      #1;
      check(word_o == '0 && !word_vld_o && !dec_err_o, "R1 reset state",
            word_o, '0);
      @(negedge clk_i);
      rst_ni = 1'b1;

      // sweep every previous/current group pairing
      for (int p = 0; p < 8; p++) begin
         for (int c = 0; c < 8; c++) begin
            do_clear(1'b0);
            send_group(3'(p));
            if (((p + c) % 2) == 1) begin
               idle(1'b1);
               idle(1'b0);
            end
            send_group(3'(c));
            check(seen_err == ref_pair({3'(p), 3'(c)})[2],
                  {pat_tag({p[0], 3'(c)}), " second group error"},
                  W'(seen_err), W'(ref_pair({3'(p), 3'(c)})[2]));
            for (int f = 0; f < 16; f++) begin
               send_group(3'b101);
               if (f == 7 && c[0]) idle(1'b1);
            end
            // R8: first group sees 0,0,1 ahead of it
            pe = ref_pair({3'b001, 3'(p)});
            check(last_word[W-1 -: 2] == pe[1:0], "R8 first group after clear",
                  W'(last_word[W-1 -: 2]), W'(pe[1:0]));
            pe = ref_pair({3'(p), 3'(c)});
            check(last_word[W-3 -: 2] == pe[1:0],
                  {pat_tag({p[0], 3'(c)}), " pair value"},
                  W'(last_word[W-3 -: 2]), W'(pe[1:0]));
         end
      end

      // R10: error on the final group of a word
      do_clear(1'b0);
      for (int f = 0; f < 17; f++) send_group(3'b101);
      send_group(3'b000);
      check(seen_err && seen_wv, "R10 error with word strobe",
            W'({seen_err, seen_wv}), W'(2'b11));
      check(last_word[1:0] == 2'b00, "R10 error pair zero",
            W'(last_word[1:0]), '0);
      send_group(3'b101);
      check(!seen_err, "R6 decoding continues", W'(seen_err), '0);

      // R9: clear mid-word, then a full word with varied groups
      do_clear(1'b0);
      for (int f = 0; f < 7; f++) send_group(3'b101);
      send_bit(1'b1);
      do_clear(1'b0);
      for (int f = 0; f < 18; f++) send_group(3'((f * 5 + 3) % 8));
      check(seen_wv, "R9 full word after mid-word clear", W'(seen_wv), W'(1));

      // R9: clear collides with the third bit of a group
      send_bit(1'b1);
      send_bit(1'b0);
      do_clear(1'b1);
      for (int f = 0; f < 18; f++) send_group(3'((f * 3 + 1) % 8));
      check(seen_wv, "R9 realigned word after colliding clear", W'(seen_wv), W'(1));

      idle(1'b0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule